// File: doc/BRIEF.md
# Security Fault Status Recorder

This block keeps the record of security faults raised by a processor core. The core sends one-cycle strobes, one per kind of security fault, together with the faulting address and a qualifier that says whether that address is meaningful. Each strobe sets a sticky flag in a status register. The first qualified faulting address is captured into an address register and an address-valid flag is raised. Software reads both registers over a simple register bus and clears flags by writing ones.

An attribution violation raised while the core is saving floating-point state lazily is reported on the lazy-preservation flag, not the attribution flag. The address-valid flag can also be dropped by a fault of another class, such as a bus fault. Capture is controlled by a two-state machine. In state `CAP_IDLE` no address is held. The transition `CAPTURE` loads the address and moves to `CAP_HELD`. In `CAP_HELD` the first address is kept. The transition `RELEASE` returns to `CAP_IDLE` on a software clear of the valid bit or on an external fault clear. When a qualified event arrives in the same cycle as either clear, the set wins and the machine takes `CAPTURE` from idle or stays in `CAP_HELD`.

Top module: `sec_fault_recorder`

## Requirements
- R1: The status register is at byte offset 0x14 and the address register at 0x18. A read (`reg_sel`=1, `reg_wr`=0) of any other offset returns 0, and `reg_rdata` is 0 whenever no read is in progress. The status bits are: 0 invalid entry, 1 bad integrity signature, 2 bad exception return, 3 attribution violation, 4 invalid transition, 5 lazy-preservation violation, 6 address valid, 7 lazy-state error. Status bits 31:8 read as 0.
- R2: After reset both registers read 0 and the capture machine is in `CAP_IDLE`.
- R3: The `evt_strobe` bits 0, 1, 2, 3, 4, 5 and 6 set status bits 0, 1, 2, 3, 4, 5 and 7. Each flag is visible in the cycle after its strobe.
- R4: Strobe bit 3 with `lazy_active`=1 sets status bit 5 and leaves bit 3 unchanged. With `lazy_active`=0 it sets bit 3.
- R5: A write to offset 0x14 clears each status bit whose `reg_wdata` bit is 1, and a 0 bit has no effect. Writes to offset 0x18 or to any other offset change nothing.
- R6: A set flag stays set until it is cleared.
- R7: In `CAP_IDLE`, any strobe with `evt_addr_ok`=1 loads `evt_addr` into the address register and sets status bit 6. A strobe with `evt_addr_ok`=0 does neither.
- R8: In `CAP_HELD`, later qualified events do not change the address register.
- R9: `ext_fault_clr`=1 clears status bit 6 (`RELEASE`), and the address register keeps its value.
- R10: If a set and a clear hit the same bit in the same cycle, the bit ends up set. A qualified event in `CAP_HELD` together with a clear of bit 6 keeps the old address. The same combination in `CAP_IDLE` loads the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_strobe | input | 7 | One-cycle fault strobes, bit order as in R3 |
| lazy_active | input | 1 | Lazy floating-point state preservation in progress |
| evt_addr | input | 32 | Faulting address for the strobes of this cycle |
| evt_addr_ok | input | 1 | `evt_addr` is meaningful |
| ext_fault_clr | input | 1 | Fault of another class taken; drops address-valid |
| reg_sel | input | 1 | Register access this cycle |
| reg_wr | input | 1 | Access is a write |
| reg_addr | input | 8 | Byte offset of the access |
| reg_wdata | input | 32 | Write data (ones clear status bits) |
| reg_rdata | output | 32 | Read data, combinational |

## Verification
The assertions assume that `evt_strobe`, `lazy_active`, `evt_addr_ok` and `ext_fault_clr` change only between clock edges and are never unknown after reset. They also assume that a register access lasts exactly one cycle. The stimulus drives every input on the falling edge and returns the strobes to zero right after each rising edge. Reads are made only in the idle part of a cycle, so no capture assertion can see a strobe held over two edges. Collisions between a set and a clear are produced on purpose, in both capture states.

// File: rtl/sfr_pkg.sv
package sfr_pkg;
    localparam int NUM_EVT = 7;
    localparam int FLAG_W  = 8;

    // status bit positions
    localparam int BIT_ENTRY   = 0;
    localparam int BIT_INTEG   = 1;
    localparam int BIT_EXCRET  = 2;
    localparam int BIT_ATTRIB  = 3;
    localparam int BIT_TRANS   = 4;
    localparam int BIT_LAZYPRS = 5;
    localparam int BIT_VALID   = 6;
    localparam int BIT_LAZYERR = 7;

    // strobe positions
    localparam int EV_ENTRY   = 0;
    localparam int EV_INTEG   = 1;
    localparam int EV_EXCRET  = 2;
    localparam int EV_ATTRIB  = 3;
    localparam int EV_TRANS   = 4;
    localparam int EV_LAZYPRS = 5;
    localparam int EV_LAZYERR = 6;

    typedef enum logic {
        CAP_IDLE = 1'b0,
        CAP_HELD = 1'b1
    } cap_state_e;
endpackage

// File: rtl/sfr_flags.sv
module sfr_flags
    import sfr_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               lazy_active,
    input  logic [FLAG_W-1:0]  clr_mask,
    output logic [FLAG_W-1:0]  flags_q
);
    logic [FLAG_W-1:0] set_vec;

    always_comb begin
        set_vec              = '0;
        set_vec[BIT_ENTRY]   = evt_strobe[EV_ENTRY];
        set_vec[BIT_INTEG]   = evt_strobe[EV_INTEG];
        set_vec[BIT_EXCRET]  = evt_strobe[EV_EXCRET];
        set_vec[BIT_ATTRIB]  = evt_strobe[EV_ATTRIB] & ~lazy_active;
        set_vec[BIT_TRANS]   = evt_strobe[EV_TRANS];
        set_vec[BIT_LAZYPRS] = evt_strobe[EV_LAZYPRS]
                             | (evt_strobe[EV_ATTRIB] & lazy_active);
        set_vec[BIT_LAZYERR] = evt_strobe[EV_LAZYERR];
    end

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        if (i == BIT_VALID) begin : g_hole
            // address-valid lives in the capture machine
            assign flags_q[i] = set_vec[i];
        end else begin : g_sticky
            logic bit_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) bit_q <= 1'b0;
                else        bit_q <= set_vec[i] | (bit_q & ~clr_mask[i]);
            end
            assign flags_q[i] = bit_q;

            // R6: held unless cleared
            a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
                (bit_q && !clr_mask[i]) |=> bit_q);
            // R10: set beats clear
            a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
                (set_vec[i] && clr_mask[i]) |=> bit_q);
        end
    end

    // R4: lazy attribution lands on the lazy-preservation flag
    a_r4_lazy_route: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_strobe[EV_ATTRIB] && lazy_active) |=> flags_q[BIT_LAZYPRS]);
    // R3: strobe raises its flag
    a_r3_entry_set: assert property (@(posedge clk) disable iff (!rst_n)
        evt_strobe[EV_ENTRY] |=> flags_q[BIT_ENTRY]);
endmodule

// File: rtl/sfr_capture.sv
module sfr_capture
    import sfr_pkg::*;
#(
    parameter int FADDR_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               any_evt,
    input  logic               addr_ok,
    input  logic [FADDR_W-1:0] evt_addr,
    input  logic               sw_clr,
    input  logic               ext_clr,
    output logic               valid,
    output logic [FADDR_W-1:0] addr_q
);
    cap_state_e state_q, state_d;
    logic       qual_evt;
    logic       load_en;

    assign qual_evt = any_evt & addr_ok;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CAP_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CAP_IDLE: if (qual_evt) state_d = CAP_HELD;            // CAPTURE
            CAP_HELD: if (!qual_evt && (sw_clr || ext_clr))
                          state_d = CAP_IDLE;                      // RELEASE
            default:  state_d = CAP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        valid   = (state_q == CAP_HELD);
        load_en = (state_q == CAP_IDLE) && qual_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       addr_q <= '0;
        else if (load_en) addr_q <= evt_addr;
    end

    // R7: capture in idle
    a_r7_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && qual_evt) |=> (valid && addr_q == $past(evt_addr)));
    // R8: first address kept
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> $stable(addr_q));
    // R9: external clear drops valid
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_clr && !qual_evt) |=> !valid);
    // R10: qualified event wins over clears
    a_r10_valid_wins: assert property (@(posedge clk) disable iff (!rst_n)
        qual_evt |=> valid);
endmodule

// File: rtl/sfr_regif.sv
module sfr_regif
    import sfr_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          FADDR_W     = 32,
    parameter logic [7:0]  STATUS_OFS  = 8'h14,
    parameter logic [7:0]  FADDR_OFS   = 8'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    input  logic [FLAG_W-1:0]  status,
    input  logic [FADDR_W-1:0] faddr,
    output logic [FLAG_W-1:0]  clr_mask,
    output logic [DATA_W-1:0]  reg_rdata
);
    localparam logic [ADDR_W-1:0] ST_A = ADDR_W'(STATUS_OFS);
    localparam logic [ADDR_W-1:0] FA_A = ADDR_W'(FADDR_OFS);

    logic rd_en, wr_st;
    logic unused_wdata;

    assign rd_en        = reg_sel & ~reg_wr;
    assign wr_st        = reg_sel & reg_wr & (reg_addr == ST_A);
    assign unused_wdata = ^reg_wdata[DATA_W-1:FLAG_W];

    always_comb begin
        clr_mask = wr_st ? reg_wdata[FLAG_W-1:0] : '0;
    end

    always_comb begin
        reg_rdata = '0;
        if (rd_en) begin
            if (reg_addr == ST_A)      reg_rdata[FLAG_W-1:0] = status;
            else if (reg_addr == FA_A) reg_rdata = DATA_W'(faddr);
        end
    end

    // R1: idle bus returns zero
    a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (reg_rdata == '0));
    // R1: status upper bits zero
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ST_A) |-> (reg_rdata[DATA_W-1:FLAG_W] == '0));
endmodule

// File: rtl/sec_fault_recorder.sv
module sec_fault_recorder
    import sfr_pkg::*;
#(
    parameter int         ADDR_W     = 8,
    parameter int         DATA_W     = 32,
    parameter int         FADDR_W    = 32,
    parameter logic [7:0] STATUS_OFS = 8'h14,
    parameter logic [7:0] FADDR_OFS  = 8'h18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_EVT-1:0] evt_strobe,
    input  logic               lazy_active,
    input  logic [FADDR_W-1:0] evt_addr,
    input  logic               evt_addr_ok,
    input  logic               ext_fault_clr,
    input  logic               reg_sel,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata
);
    logic [FLAG_W-1:0]  flags_q;
    logic [FLAG_W-1:0]  clr_mask;
    logic [FLAG_W-1:0]  status;
    logic [FADDR_W-1:0] faddr_q;
    logic               addr_valid;

    sfr_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .evt_strobe (evt_strobe),
        .lazy_active(lazy_active),
        .clr_mask   (clr_mask),
        .flags_q    (flags_q)
    );

    sfr_capture #(.FADDR_W(FADDR_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_evt (|evt_strobe),
        .addr_ok (evt_addr_ok),
        .evt_addr(evt_addr),
        .sw_clr  (clr_mask[BIT_VALID]),
        .ext_clr (ext_fault_clr),
        .valid   (addr_valid),
        .addr_q  (faddr_q)
    );

    always_comb begin
        status            = flags_q;
        status[BIT_VALID] = addr_valid;
    end

    sfr_regif #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .FADDR_W   (FADDR_W),
        .STATUS_OFS(STATUS_OFS),
        .FADDR_OFS (FADDR_OFS)
    ) u_regif (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_sel  (reg_sel),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .status   (status),
        .faddr    (faddr_q),
        .clr_mask (clr_mask),
        .reg_rdata(reg_rdata)
    );
endmodule

// File: tb/sim_sec_fault_recorder.sv
`timescale 1ns/1ps
module sim_sec_fault_recorder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt_strobe = '0;
    logic        lazy_active = 1'b0;
    logic [31:0] evt_addr = '0;
    logic        evt_addr_ok = 1'b0;
    logic        ext_fault_clr = 1'b0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    // reference model state
    logic [7:0]  m_flags = '0;
    logic        m_valid = 1'b0;
    logic [31:0] m_addr  = '0;

    always #2.5 clk = ~clk;

    sec_fault_recorder u0 (
        .clk(clk), .rst_n(rst_n), .evt_strobe(evt_strobe),
        .lazy_active(lazy_active), .evt_addr(evt_addr),
        .evt_addr_ok(evt_addr_ok), .ext_fault_clr(ext_fault_clr),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] m_status();
        logic [7:0] s;
        s    = m_flags;
        s[6] = m_valid;
        return {24'h0, s};
    endfunction

    task automatic read_both(input string tag);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 8'h14;
        #0.5 check({tag, " status"}, reg_rdata, m_status());
        reg_addr = 8'h18;
        #0.5 check({tag, " address"}, reg_rdata, m_addr);
        reg_sel = 1'b0; reg_addr = 8'h00;
    endtask

    // one clock of stimulus, model update and comparison
    task automatic step(input string tag, input logic [6:0] s, input logic lz,
                        input logic [31:0] a, input logic ok, input logic xc,
                        input logic wr_en, input logic [7:0] woff, input logic [7:0] wmask);
        logic [7:0] setv, clrv;
        @(negedge clk);
        evt_strobe = s; lazy_active = lz; evt_addr = a; evt_addr_ok = ok;
        ext_fault_clr = xc;
        reg_sel = wr_en; reg_wr = wr_en; reg_addr = woff;
        reg_wdata = {24'hA5A5A5, wmask};
        @(posedge clk);
        setv    = '0;
        setv[0] = s[0]; setv[1] = s[1]; setv[2] = s[2];
        setv[3] = s[3] & ~lz; setv[4] = s[4];
        setv[5] = s[5] | (s[3] & lz); setv[7] = s[6];
        clrv    = (wr_en && woff == 8'h14) ? wmask : 8'h00;
        m_flags = (setv | (m_flags & ~clrv)) & 8'hBF;
        if ((|s) && ok) begin
            if (!m_valid) m_addr = a;
            m_valid = 1'b1;
        end else if (clrv[6] || xc) begin
            m_valid = 1'b0;
        end
        #0.5;
        evt_strobe = '0; lazy_active = 1'b0; evt_addr_ok = 1'b0;
        ext_fault_clr = 1'b0; reg_wr = 1'b0; reg_sel = 1'b0; reg_wdata = '0;
        read_both(tag);
    endtask

    task automatic idle(input string tag);
        step(tag, 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 read_both("R2 reset");
        rst_n = 1'b1;
        idle("R2 after reset");

        // R1: bus decode
        @(negedge clk);
        reg_sel = 1'b1; reg_wr = 1'b0; reg_addr = 8'h1C;
        #0.5 check("R1 unmapped read", reg_rdata, 32'h0);
        reg_sel = 1'b0; reg_addr = 8'h14;
        #0.5 check("R1 no select", reg_rdata, 32'h0);

        // R7/R3: first qualified event captures
        step("R7 capture", 7'b0000001, 1'b0, 32'h1000_0040, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R8: second qualified event keeps first address
        step("R8 keep first", 7'b0000010, 1'b0, 32'h2000_0080, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R3: other strobes without address
        step("R3 excret+trans", 7'b0010100, 1'b0, 32'hDEAD_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R3 lazyerr", 7'b1000000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R4: attribution routing
        step("R4 attrib lazy", 7'b0001000, 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R4 attrib plain", 7'b0001000, 1'b0, 32'h0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        // R6: sticky
        idle("R6 sticky a");
        idle("R6 sticky b");
        // R5: write-one-to-clear
        step("R5 zero mask", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, 8'h00);
        step("R5 clear bit0", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, 8'h01);
        step("R5 addr reg write ignored", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h18, 8'hFF);
        step("R5 other offset ignored", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h10, 8'hFF);
        // R9: external release
        step("R9 ext clear", 7'h00, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        // R7: unqualified strobe does not capture
        step("R7 no addr_ok", 7'b0000001, 1'b0, 32'h5555_0000, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
        step("R7 recapture", 7'b0010000, 1'b0, 32'h3000_00C0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        // R10: collisions
        step("R10 flag set wins", 7'b0000010, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, 8'h02);
        step("R10 held clear+event", 7'b0000100, 1'b0, 32'h4000_0100, 1'b1, 1'b0, 1'b1, 8'h14, 8'h40);
        step("R10 held ext+event", 7'b0000100, 1'b0, 32'h4400_0100, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
        step("R5 clear valid", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, 8'h40);
        step("R10 idle clear+event", 7'b0000001, 1'b0, 32'h5000_0140, 1'b1, 1'b0, 1'b1, 8'h14, 8'h40);
        // R5: clear everything
        step("R5 clear all", 7'h00, 1'b0, 32'h0, 1'b0, 1'b0, 1'b1, 8'h14, 8'hFF);
        step("R9 ext idle", 7'h00, 1'b0, 32'h0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        // R3: all strobes together, lazy off
        step("R3 all strobes", 7'h7F, 1'b0, 32'h6000_0180, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule